// File: doc/BRIEF.md
# Pointer-Relative Byte Operation Executor

This block carries out three single-word instructions whose data operand lives in memory at a pointer register plus a small literal offset. The supported operations are an 8-bit add of the working register into the addressed byte, with either the working register or the byte as the destination; setting one chosen bit of the addressed byte; and filling the addressed byte with all ones. The add updates five arithmetic flags; the two bit operations leave the flags alone.

A host presents a 16-bit instruction word with a one-clock `start` strobe while the block is idle. The sequencer then steps through named states: `ST_IDLE` → `ST_DECODE` → `ST_READ` → `ST_PROC` → `ST_WRITE` → `ST_FINISH` → `ST_IDLE`. `ST_DECODE` goes straight to `ST_FINISH` when the word is illegal. Data memory is a synchronous byte port: a read issued in `ST_READ` returns data on the next clock for use in `ST_PROC`, and a write only happens in `ST_WRITE`. A load strobe, accepted only while idle, presets the working register and the pointer, which are brought out together with the flags and an illegal-word indicator.

Top module: `idx_exec`

## Requirements
- R1: After reset, the working register, pointer, flags, `done`, `illegal`, `mem_rd_en` and `mem_wr_en` are all zero.
- R2: The operand address is (pointer + k) modulo 2^AW, where k is `instr[7:0]`. `mem_rd_en` is high for exactly the second clock after the one in which `start` is accepted. `mem_wr_en` is high only in the fourth clock after that. `done` is high in the fifth clock after that.
- R3: Add words match `0010 01d0 kkkkkkkk`. With d=0 (`instr[9]`), the 8-bit sum of the working register and the byte goes to the working register, and memory is not written.
- R4: An add with d=1 writes the 8-bit sum back to the addressed byte and leaves the working register unchanged.
- R5: An add sets `flags` as follows: bit0 = carry out of bit 7, bit1 = carry out of bit 3, bit2 = result zero, bit3 = signed overflow (both operands have the same sign and the result sign differs), bit4 = result bit 7.
- R6: A bit-set word `1000 bbb0 kkkkkkkk` writes the byte with bit b (`instr[11:9]`) forced to 1. The working register and the flags stay unchanged.
- R7: A set-all word `0110 1000 kkkkkkkk` writes FFh to the byte. The working register and the flags stay unchanged.
- R8: A word with k > 95, or one that matches none of the three patterns, raises `illegal`. Such a word performs no memory read or write and changes neither the working register nor the flags. It pulses `done` in the second clock after acceptance. `illegal` holds until the next accepted `start`.
- R9: `done` is a single-clock pulse. A `start` that arrives while an instruction is in flight is ignored.
- R10: While idle and with `start` low, `load` copies `load_wreg` into the working register and `load_ptr` into the pointer on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept `instr` while idle |
| instr | input | 16 | Instruction word |
| load | input | 1 | Preset working register and pointer while idle |
| load_wreg | input | DW | Working register preset value |
| load_ptr | input | AW | Pointer preset value |
| done | output | 1 | One-clock completion pulse |
| illegal | output | 1 | Last accepted word was illegal |
| mem_addr | output | AW | Data memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one clock after the read strobe |
| wreg | output | DW | Working register |
| ptr | output | AW | Pointer register |
| flags | output | 5 | Flags {N, OV, Z, DC, C} |

## Verification
The bench builds the block with its defaults: AW=12, DW=8 and an offset limit of 95. These values give a full 4096-byte memory model. With them, pointers near FFFh make the address wrap, and offsets of 95 and 96 fall on either side of the legality limit. An 8-bit datapath lets random operand pairs and directed pairs reach every flag combination, including a carry with a zero result and a signed overflow without a carry.

// File: rtl/idx_pkg.sv
package idx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_DECODE, ST_READ, ST_PROC, ST_WRITE, ST_FINISH
    } phase_t;

    typedef enum logic [1:0] {
        OP_ADD, OP_BSET, OP_SETALL, OP_NONE
    } op_t;

    localparam int KW     = 8;
    localparam int NFLAGS = 5;
    localparam int FLAG_C  = 0;
    localparam int FLAG_DC = 1;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_OV = 3;
    localparam int FLAG_N  = 4;

    typedef struct packed {
        op_t           op;
        logic          to_mem;
        logic [2:0]    bsel;
        logic [KW-1:0] k;
        logic          bad;
    } dec_t;
endpackage

// File: rtl/idx_decode.sv
module idx_decode
    import idx_pkg::*;
#(
    parameter int KMAX = 95
) (
    input  logic [15:0] word,
    output dec_t        dec
);
    always_comb begin
        dec        = '0;
        dec.op     = OP_NONE;
        dec.k      = word[7:0];
        dec.bsel   = word[11:9];
        if (word[15:10] == 6'b001001 && !word[8]) begin
            dec.op     = OP_ADD;
            dec.to_mem = word[9];
        end else if (word[15:12] == 4'b1000 && !word[8]) begin
            dec.op     = OP_BSET;
            dec.to_mem = 1'b1;
        end else if (word[15:8] == 8'h68) begin
            dec.op     = OP_SETALL;
            dec.to_mem = 1'b1;
        end
        dec.bad = (dec.op == OP_NONE) || (int'(word[7:0]) > KMAX);
    end
endmodule

// File: rtl/idx_alu.sv
module idx_alu
    import idx_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  op_t               op,
    input  logic [BW-1:0]     bsel,
    input  logic [DW-1:0]     wval,
    input  logic [DW-1:0]     mval,
    output logic [DW-1:0]     res,
    output logic [NFLAGS-1:0] flg
);
    logic [DW:0] sum;
    logic [4:0]  low;

    always_comb begin
        sum = {1'b0, wval} + {1'b0, mval};
        low = {1'b0, wval[3:0]} + {1'b0, mval[3:0]};
        unique case (op)
            OP_ADD:    res = sum[DW-1:0];
            OP_BSET:   res = mval | (DW'(1) << bsel);
            OP_SETALL: res = '1;
            default:   res = mval;
        endcase
        flg          = '0;
        flg[FLAG_C]  = sum[DW];
        flg[FLAG_DC] = low[4];
        flg[FLAG_Z]  = (sum[DW-1:0] == '0);
        flg[FLAG_OV] = (wval[DW-1] == mval[DW-1]) && (sum[DW-1] != wval[DW-1]);
        flg[FLAG_N]  = sum[DW-1];
    end
endmodule

// File: rtl/idx_exec.sv
module idx_exec
    import idx_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 8,
    parameter int KMAX = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic              load,
    input  logic [DW-1:0]     load_wreg,
    input  logic [AW-1:0]     load_ptr,
    output logic              done,
    output logic              illegal,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     wreg,
    output logic [AW-1:0]     ptr,
    output logic [NFLAGS-1:0] flags
);
    phase_t            st_q, st_d;
    logic [15:0]       ir_q;
    dec_t              dec, dec_q;
    logic [AW-1:0]     addr_q, ptr_q;
    logic [DW-1:0]     res_q, wreg_q, alu_res;
    logic [NFLAGS-1:0] flg_q, flags_q, alu_flg;
    logic              illegal_q;

    idx_decode #(.KMAX(KMAX)) u_dec (.word(ir_q), .dec(dec));

    idx_alu #(.DW(DW)) u_alu (
        .op(dec_q.op), .bsel(dec_q.bsel[$clog2(DW)-1:0]),
        .wval(wreg_q), .mval(mem_rdata), .res(alu_res), .flg(alu_flg)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_DECODE;
            ST_DECODE: st_d = dec.bad ? ST_FINISH : ST_READ;
            ST_READ:   st_d = ST_PROC;
            ST_PROC:   st_d = ST_WRITE;
            ST_WRITE:  st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q      <= '0;
            dec_q     <= '0;
            addr_q    <= '0;
            res_q     <= '0;
            flg_q     <= '0;
            wreg_q    <= '0;
            ptr_q     <= '0;
            flags_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        ir_q      <= instr;
                        illegal_q <= 1'b0;
                    end else if (load) begin
                        wreg_q <= load_wreg;
                        ptr_q  <= load_ptr;
                    end
                end
                ST_DECODE: begin
                    dec_q     <= dec;
                    addr_q    <= ptr_q + AW'(dec.k);
                    illegal_q <= dec.bad;
                end
                ST_PROC: begin
                    res_q <= alu_res;
                    flg_q <= alu_flg;
                end
                ST_WRITE: begin
                    if (dec_q.op == OP_ADD) begin
                        flags_q <= flg_q;
                        if (!dec_q.to_mem) wreg_q <= res_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = (st_q == ST_READ);
        mem_wr_en = (st_q == ST_WRITE) && dec_q.to_mem;
        done      = (st_q == ST_FINISH);
        mem_addr  = addr_q;
        mem_wdata = res_q;
        illegal   = illegal_q;
        wreg      = wreg_q;
        ptr       = ptr_q;
        flags     = flags_q;
    end
endmodule

// File: rtl/idx_exec_chk.sv
module idx_exec_chk #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic          done,
    input logic          illegal,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [DW-1:0] wreg,
    input logic [4:0]    flags
);
    // R2: a write is always two clocks after a read
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2));

    // R2: read strobe lasts one clock
    a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R9: done is a one-clock pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an illegal word never writes memory
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_wr_en);

    // R8: an illegal word leaves the working register and flags as they were
    a_r8_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> ($stable(wreg) && $stable(flags)));

    // R5: flags only move at instruction completion
    a_r5_flags_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flags) |-> done);

    // R10: working register only moves at completion or after a load
    a_r10_wreg_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wreg) |-> (done || $past(load)));
endmodule

bind idx_exec idx_exec_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .done(done), .illegal(illegal),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .wreg(wreg), .flags(flags)
);

// File: tb/test_idx_exec.sv
`timescale 1ns/1ps
module test_idx_exec;
    localparam int AW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   instr = '0;
    logic          load = 1'b0;
    logic [DW-1:0] load_wreg = '0;
    logic [AW-1:0] load_ptr = '0;
    logic          done, illegal, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr, ptr;
    logic [DW-1:0] mem_wdata, wreg;
    logic [DW-1:0] mem_rdata = '0;
    logic [4:0]    flags;

    logic [7:0]    mem [0:(1<<AW)-1];
    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_wa = '0;
    logic [7:0]    tb_wd = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_w;
    logic [11:0] m_p;
    logic [4:0]  m_f;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        else if (tb_we) mem[tb_wa] <= tb_wd;
    end

    idx_exec i_idx_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .load(load),
        .load_wreg(load_wreg), .load_ptr(load_ptr), .done(done), .illegal(illegal),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wreg(wreg), .ptr(ptr),
        .flags(flags)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic preload(input logic [7:0] w, input logic [11:0] p);
        @(negedge clk);
        load = 1'b1; load_wreg = w; load_ptr = p;
        @(negedge clk);
        load = 1'b0;
        m_w = w; m_p = p;
        check(wreg == w && ptr == p, "R10 load", {wreg, 4'h0, ptr}, {w, 4'h0, p});
    endtask

    function automatic int kind_of(input logic [15:0] iw);
        if (iw[7:0] > 8'd95) return 3;
        if (iw[15:10] == 6'b001001 && iw[8] == 1'b0) return 0;
        if (iw[15:12] == 4'b1000 && iw[8] == 1'b0) return 1;
        if (iw[15:8] == 8'h68) return 2;
        return 3;
    endfunction

    function automatic logic [4:0] add_flags(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        logic [4:0] f;
        s = {1'b0, a} + {1'b0, b};
        f[0] = s[8];
        f[1] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        f[2] = (s[7:0] == 8'h00);
        f[3] = (a[7] == b[7]) && (s[7] != a[7]);
        f[4] = s[7];
        return f;
    endfunction

    // Runs one word; optionally pulses start again mid-flight (R9)
    task automatic run(input logic [15:0] iw, input logic restart);
        int          kind;
        logic [11:0] ea;
        logic [7:0]  old, exp_m, exp_w;
        logic [4:0]  exp_f;
        int          rd_cyc, wr_cyc, done_cyc, wr_n;
        logic [11:0] rd_addr;
        kind = kind_of(iw);
        ea   = m_p + {4'h0, iw[7:0]};
        old  = mem[ea];
        exp_m = old; exp_w = m_w; exp_f = m_f;
        case (kind)
            0: begin
                exp_f = add_flags(m_w, old);
                if (iw[9]) exp_m = m_w + old;
                else       exp_w = m_w + old;
            end
            1: exp_m = old | (8'h01 << iw[11:9]);
            2: exp_m = 8'hFF;
            default: ;
        endcase
        rd_cyc = 0; wr_cyc = 0; done_cyc = 0; wr_n = 0; rd_addr = '0;
        @(negedge clk);
        instr = iw; start = 1'b1;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            start = (restart && c == 2);
            if (restart && c == 2) instr = {8'h68, 8'h00};
            if (mem_rd_en) begin rd_cyc = c; rd_addr = mem_addr; end
            if (mem_wr_en) begin wr_cyc = c; wr_n++; end
            if (done && done_cyc == 0) done_cyc = c;
            else if (done) check(1'b0, "R9 second done", c, 0);
        end
        start = 1'b0;
        if (kind == 3) begin
            check(illegal == 1'b1, "R8 illegal flag", illegal, 1);
            check(done_cyc == 2 && rd_cyc == 0 && wr_n == 0, "R8 no access",
                  {done_cyc, rd_cyc, wr_n}, {2, 0, 0});
        end else begin
            check(illegal == 1'b0, "R8 legal not flagged", illegal, 0);
            check(rd_cyc == 2 && rd_addr == ea, "R2 read timing/address",
                  {rd_cyc, 4'h0, rd_addr}, {2, 4'h0, ea});
            check(done_cyc == 5, "R2 done latency", done_cyc, 5);
            if (kind == 0 && !iw[9]) check(wr_n == 0, "R3 no mem write", wr_n, 0);
            else check(wr_n == 1 && wr_cyc == 4, "R2 write timing", wr_cyc, 4);
        end
        case (kind)
            0: begin
                if (iw[9]) check(mem[ea] == exp_m && wreg == exp_w, "R4 add to byte", {mem[ea], wreg}, {exp_m, exp_w});
                else       check(mem[ea] == exp_m && wreg == exp_w, "R3 add to wreg", {mem[ea], wreg}, {exp_m, exp_w});
                check(flags == exp_f, "R5 add flags", flags, exp_f);
            end
            1: check(mem[ea] == exp_m && wreg == exp_w && flags == exp_f, "R6 bit set",
                     {mem[ea], wreg, 3'b0, flags}, {exp_m, exp_w, 3'b0, exp_f});
            2: check(mem[ea] == exp_m && wreg == exp_w && flags == exp_f, "R7 set all",
                     {mem[ea], wreg, 3'b0, flags}, {exp_m, exp_w, 3'b0, exp_f});
            default: check(mem[ea] == old && wreg == exp_w && flags == exp_f, "R8 state kept",
                     {mem[ea], wreg, 3'b0, flags}, {old, exp_w, 3'b0, exp_f});
        endcase
        if (restart) check(mem[m_p] != 8'hFF || kind == 2, "R9 start ignored while busy", mem[m_p], 0);
        m_w = exp_w; m_f = exp_f;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < (1 << AW); a++) mem[a] = 8'(a * 37 + 5);
        m_w = '0; m_p = '0; m_f = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wreg == 0 && ptr == 0 && flags == 0 && !done && !illegal && !mem_rd_en && !mem_wr_en,
              "R1 reset state", {wreg, flags}, 0);

        // directed vectors
        preload(8'h17, 12'hA00);
        poke(12'hA2C, 8'h20);
        run({8'h24, 8'h2C}, 1'b0);           // R3: 17h+20h -> W=37h
        check(wreg == 8'h37 && mem[12'hA2C] == 8'h20, "R3 vector", wreg, 8'h37);
        poke(12'hA0A, 8'h55);
        run({8'h8E, 8'h0A}, 1'b0);           // R6: bit 7 -> D5h
        check(mem[12'hA0A] == 8'hD5, "R6 vector", mem[12'hA0A], 8'hD5);
        preload(8'h80, 12'h100);
        poke(12'h15F, 8'h80);
        run({8'h26, 8'h5F}, 1'b0);           // R4/R5: k=95, carry+zero+overflow
        check(flags == 5'b01101, "R5 carry zero overflow", flags, 5'b01101);
        run({8'h68, 8'h60}, 1'b0);           // R8: k=96 illegal
        run({8'hFF, 8'h01}, 1'b0);           // R8: unknown opcode
        preload(8'h0F, 12'hFF0);
        run({8'h68, 8'h20}, 1'b0);           // R7: wraps to 010h
        run({8'h24, 8'h30}, 1'b0);           // R3 with wrap
        preload(8'h44, 12'h300);
        poke(12'h300, 8'h00);
        run({8'h82, 8'h05}, 1'b1);           // R9: extra start mid-flight

        // random vectors
        for (int i = 0; i < 300; i++) begin
            logic [15:0] iw;
            int sel;
            if (i % 20 == 0) preload(8'($urandom), 12'($urandom));
            sel = int'($urandom % 5);
            case (sel)
                0: iw = {6'b001001, 1'($urandom), 1'b0, 8'($urandom % 96)};
                1: iw = {4'b1000, 3'($urandom), 1'b0, 8'($urandom % 96)};
                2: iw = {8'h68, 8'($urandom % 96)};
                3: iw = {6'b001001, 1'($urandom), 1'b0, 8'(96 + $urandom % 160)};
                default: iw = 16'($urandom);
            endcase
            run(iw, 1'b0);
        end
        finish_run();
    end
endmodule